// File: doc/BRIEF.md
# Synchronous Slave Serial Transmitter

This block sends data words over a two-wire synchronous serial line whose shift clock is supplied by an external master. The host writes words into a holding register. A word written while the shift register is idle moves straight into the shift register. A word written while a frame is still leaving is held back until that frame ends. Each frame is 8 data bits, or 9 bits when the ninth-bit mode is on. In 9-bit mode the extra bit is taken from a host control bit at the moment of the write.

The line clock is brought into the system clock domain through a two-flop synchronizer with edge detection. The data output moves to the next bit, least significant first, after each rising edge of the line clock. The master samples it on the falling edge.

A buffer-empty flag rises only at the moment a held word moves into the shift register. Loading the first word does not raise it. Together with its enable, the flag forms an interrupt request that needs no clock activity other than the line clock. A shift-register-empty status bit shows whether any frame is still being sent.

Top module: `sync_slave_tx`

## Requirements
- R1: After reset, `tx_data` is 1 (idle), `shift_empty` is 1, and `buf_empty` and `irq` are 0.
- R2: The transmitter is active only when `port_en`, `sync_mode` and `tx_en` are 1 and `clk_master`, `rx_single_en` and `rx_cont_en` are 0. While inactive, writes are ignored, `tx_data` stays 1 and `shift_empty` stays 1.
- R3: A write made while the shift register and holding register are both empty loads the shift register directly. `shift_empty` reads 0 from the clock cycle after the write, and `buf_empty` stays 0.
- R4: Bits leave least significant first. Each bit appears on `tx_data` within three system clocks after a rising edge of `ext_clk` and holds until the next rising edge.
- R5: With `nine_bit` = 0 a frame has 8 bits. With `nine_bit` = 1 a frame has 9 bits, and bit 8 is the value of `ninth_bit` at the time of the write. Both settings are captured per word when it is written.
- R6: A word written while a frame is in the shift register stays held, and `buf_empty` stays 0 for the rest of that frame.
- R7: When the falling `ext_clk` edge that ends a frame is seen and a word is held, that word enters the shift register and `buf_empty` becomes 1. Its first bit follows on the next rising edge with no gap.
- R8: A write accepted into either register clears `buf_empty`.
- R9: `irq` is 1 exactly when `buf_empty` and `irq_en` are both 1.
- R10: When a frame ends with no word held, `shift_empty` becomes 1, and the next rising `ext_clk` edge returns `tx_data` to 1.
- R11: Dropping the transmitter out of the active state in the middle of a frame discards the shift register and any held word. `tx_data` goes to 1 and `shift_empty` goes to 1.
- R12: A write made while both the shift register and the holding register are occupied is dropped, and the held word is sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| clk_master | input | 1 | Clock source select; 0 means the clock comes from the line |
| rx_single_en | input | 1 | Single receive enable; must be 0 for transmit |
| rx_cont_en | input | 1 | Continuous receive enable; must be 0 for transmit |
| tx_en | input | 1 | Transmit enable |
| nine_bit | input | 1 | 9-bit frame select, captured at write |
| ninth_bit | input | 1 | Ninth data bit, captured at write |
| irq_en | input | 1 | Interrupt enable for the buffer-empty flag |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Data word to send |
| ext_clk | input | 1 | Shift clock from the external master |
| tx_data | output | 1 | Serial data output, idle 1 |
| buf_empty | output | 1 | Buffer-empty flag |
| shift_empty | output | 1 | High when no frame is being sent |
| irq | output | 1 | Interrupt request |

## Verification
Random words are sent in single frames and in back-to-back pairs, with 8-bit and 9-bit frames mixed and the ninth bit changed between the two writes. This tells apart bits taken from the wrong word, bits sent in the wrong order, and a ninth bit sampled at the wrong time. Pairs tell a buffer-empty flag raised at the held-word transfer from one raised at the first load, and show whether the second frame starts without a gap. Directed cases check three things: that each enable-gating input alone blocks writes, that disabling mid-frame leaves no word behind, and that a third write into full storage is dropped.

// File: rtl/sst_pkg.sv
package sst_pkg;

  // Source of a shift register load in a given cycle
  typedef enum logic [1:0] {
    LOAD_NONE      = 2'd0,
    LOAD_DIRECT    = 2'd1,
    LOAD_FROM_HOLD = 2'd2
  } load_src_e;

  // Transmit is allowed only in synchronous slave mode with receive off
  function automatic logic tx_gate(
    input logic port_en,
    input logic sync_mode,
    input logic clk_master,
    input logic rx_single_en,
    input logic rx_cont_en,
    input logic tx_en
  );
    return port_en & sync_mode & ~clk_master & ~rx_single_en & ~rx_cont_en & tx_en;
  endfunction

endpackage

// File: rtl/sst_edge_sync.sv
module sst_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = STAGES - 1;

  // chain[0..STAGES-1] are synchronizer flops, chain[STAGES] is the history flop
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise_o = chain[LAST] & ~chain[STAGES];
  assign fall_o = ~chain[LAST] & chain[STAGES];
endmodule

// File: rtl/sst_hold_buf.sv
module sst_hold_buf #(
  parameter int FRAME_W = 9,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               push,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [LEN_W-1:0]   len_in,
  input  logic               pop,
  output logic               valid_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   len_o
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      valid_o <= 1'b0;
      frame_o <= '0;
      len_o   <= '0;
    end else if (push && !valid_o) begin
      valid_o <= 1'b1;
      frame_o <= frame_in;
      len_o   <= len_in;
    end else if (pop) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int   FRAME_W = 9,
  parameter int   LEN_W   = 4,
  parameter logic IDLE    = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_frame,
  input  logic [LEN_W-1:0]   load_len,
  input  logic               rise,
  input  logic               fall,
  output logic               busy_o,
  output logic               done_o,
  output logic               tx_o,
  output logic [LEN_W-1:0]   bits_left_o
);
  logic [FRAME_W-1:0] sh_q;

  // A frame ends on the falling edge after its last bit has been presented
  assign done_o = busy_o & fall & (bits_left_o == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sh_q        <= '0;
      bits_left_o <= '0;
      busy_o      <= 1'b0;
      tx_o        <= IDLE;
    end else if (load) begin
      busy_o <= 1'b1;
      if (rise) begin
        tx_o        <= load_frame[0];
        sh_q        <= load_frame >> 1;
        bits_left_o <= load_len - 1'b1;
      end else begin
        sh_q        <= load_frame;
        bits_left_o <= load_len;
      end
    end else if (rise) begin
      if (busy_o && bits_left_o != '0) begin
        tx_o        <= sh_q[0];
        sh_q        <= sh_q >> 1;
        bits_left_o <= bits_left_o - 1'b1;
      end else if (!busy_o) begin
        tx_o <= IDLE;
      end
    end else if (done_o) begin
      busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx #(
  parameter int   DATA_W      = 8,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LEVEL  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              sync_mode,
  input  logic              clk_master,
  input  logic              rx_single_en,
  input  logic              rx_cont_en,
  input  logic              tx_en,
  input  logic              nine_bit,
  input  logic              ninth_bit,
  input  logic              irq_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_clk,
  output logic              tx_data,
  output logic              buf_empty,
  output logic              shift_empty,
  output logic              irq
);
  import sst_pkg::*;

  localparam int FRAME_W = DATA_W + 1;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  function automatic logic [FRAME_W-1:0] build_frame(
    input logic [DATA_W-1:0] d, input logic ext, input logic b9);
    return ext ? {b9, d} : {1'b0, d};
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input logic ext);
    return ext ? LEN_W'(FRAME_W) : LEN_W'(DATA_W);
  endfunction

  // Named internal events, observed by the bound checker
  logic               active;
  logic               rise_evt, fall_evt;
  logic               busy, done_evt;
  logic               hold_valid;
  logic [FRAME_W-1:0] hold_frame;
  logic [LEN_W-1:0]   hold_len;
  logic [LEN_W-1:0]   bits_left;
  logic               wr_ok, load_direct, push_hold, load_from_hold, wr_dropped;
  load_src_e          load_src;
  logic [FRAME_W-1:0] new_frame, sh_frame;
  logic [LEN_W-1:0]   new_len, sh_len;
  logic               flag_q;

  assign active = tx_gate(port_en, sync_mode, clk_master, rx_single_en, rx_cont_en, tx_en);

  sst_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_clk),
    .rise_o(rise_evt), .fall_o(fall_evt)
  );

  assign new_frame      = build_frame(wr_data, nine_bit, ninth_bit);
  assign new_len        = frame_len(nine_bit);
  assign wr_ok          = wr_en & active;
  assign load_direct    = wr_ok & ~busy & ~hold_valid;
  assign push_hold      = wr_ok & busy & ~hold_valid;
  assign wr_dropped     = wr_ok & ~load_direct & ~push_hold;
  assign load_from_hold = active & hold_valid & (done_evt | ~busy);

  always_comb begin
    load_src = LOAD_NONE;
    if (load_from_hold)   load_src = LOAD_FROM_HOLD;
    else if (load_direct) load_src = LOAD_DIRECT;
  end

  always_comb begin
    case (load_src)
      LOAD_FROM_HOLD: begin sh_frame = hold_frame; sh_len = hold_len; end
      LOAD_DIRECT:    begin sh_frame = new_frame;  sh_len = new_len;  end
      default:        begin sh_frame = '0;         sh_len = '0;       end
    endcase
  end

  sst_hold_buf #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clear(~active),
    .push(push_hold), .frame_in(new_frame), .len_in(new_len),
    .pop(load_from_hold),
    .valid_o(hold_valid), .frame_o(hold_frame), .len_o(hold_len)
  );

  sst_shifter #(.FRAME_W(FRAME_W), .LEN_W(LEN_W), .IDLE(IDLE_LEVEL)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(~active),
    .load(load_src != LOAD_NONE), .load_frame(sh_frame), .load_len(sh_len),
    .rise(rise_evt), .fall(fall_evt),
    .busy_o(busy), .done_o(done_evt), .tx_o(tx_data), .bits_left_o(bits_left)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !active)             flag_q <= 1'b0;
    else if (load_from_hold)           flag_q <= 1'b1;
    else if (load_direct || push_hold) flag_q <= 1'b0;
  end

  assign buf_empty   = flag_q;
  assign shift_empty = ~busy;
  assign irq         = flag_q & irq_en;
endmodule

// File: rtl/sst_checker.sv
module sst_checker #(
  parameter int   FRAME_W    = 9,
  parameter int   LEN_W      = 4,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             rise_evt,
  input logic             load_direct,
  input logic             load_from_hold,
  input logic             hold_valid,
  input logic [LEN_W-1:0] bits_left,
  input logic             tx_data,
  input logic             buf_empty,
  input logic             shift_empty,
  input logic             irq_en,
  input logic             irq
);
  p_idle_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (tx_data == IDLE_LEVEL && shift_empty && !buf_empty));

  p_direct_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_direct |=> (!shift_empty && !buf_empty));

  p_stable_between_rises_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !rise_evt) |=> $stable(tx_data));

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bits_left <= LEN_W'(FRAME_W));

  p_hold_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hold_valid && !load_from_hold) |=> hold_valid);

  p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> $past(load_from_hold));

  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (buf_empty && irq_en));
endmodule

bind sync_slave_tx sst_checker #(.FRAME_W(FRAME_W), .LEN_W(LEN_W), .IDLE_LEVEL(IDLE_LEVEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .rise_evt(rise_evt),
  .load_direct(load_direct), .load_from_hold(load_from_hold),
  .hold_valid(hold_valid), .bits_left(bits_left), .tx_data(tx_data),
  .buf_empty(buf_empty), .shift_empty(shift_empty), .irq_en(irq_en), .irq(irq)
);

// File: tb/test_sync_slave_tx.sv
module test_sync_slave_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 1'b0, sync_mode = 1'b0, clk_master = 1'b0;
  logic rx_single_en = 1'b0, rx_cont_en = 1'b0, tx_en = 1'b0;
  logic nine_bit = 1'b0, ninth_bit = 1'b0, irq_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic ext_clk = 1'b0;
  logic tx_data, buf_empty, shift_empty, irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sync_slave_tx i_sync_slave_tx (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
    .clk_master(clk_master), .rx_single_en(rx_single_en), .rx_cont_en(rx_cont_en),
    .tx_en(tx_en), .nine_bit(nine_bit), .ninth_bit(ninth_bit), .irq_en(irq_en),
    .wr_en(wr_en), .wr_data(wr_data), .ext_clk(ext_clk), .tx_data(tx_data),
    .buf_empty(buf_empty), .shift_empty(shift_empty), .irq(irq)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input logic [7:0] d, input logic b9, input int i);
    return (i < 8) ? d[i] : b9;
  endfunction

  function automatic int exp_len(input logic n9);
    return n9 ? 9 : 8;
  endfunction

  task automatic ext_rise();
    ext_clk = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic ext_fall();
    ext_clk = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic write_word(input logic [7:0] d, input logic n9, input logic b9);
    @(negedge clk);
    nine_bit = n9; ninth_bit = b9; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    ninth_bit = ~b9;  // changing it after the write must not matter (R5)
  endtask

  task automatic shift_word(input logic [7:0] d, input logic n9, input logic b9, input string req);
    for (int i = 0; i < exp_len(n9); i++) begin
      ext_rise();
      check(tx_data == exp_bit(d, b9, i), req, tx_data, exp_bit(d, b9, i));
      ext_fall();
    end
  endtask

  task automatic enable_all();
    port_en = 1; sync_mode = 1; clk_master = 0; rx_single_en = 0; rx_cont_en = 0; tx_en = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R1: reset state
    check(tx_data == 1'b1, "R1 tx_data", tx_data, 1);
    check(shift_empty == 1'b1, "R1 shift_empty", shift_empty, 1);
    check(buf_empty == 1'b0 && irq == 1'b0, "R1 flag/irq", buf_empty, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: each gating input alone blocks a write
    for (int g = 0; g < 6; g++) begin
      enable_all();
      case (g)
        0: port_en = 0;
        1: sync_mode = 0;
        2: clk_master = 1;
        3: rx_single_en = 1;
        4: rx_cont_en = 1;
        default: tx_en = 0;
      endcase
      write_word(8'h00, 1'b0, 1'b0);
      check(shift_empty == 1'b1, "R2 write ignored", shift_empty, 1);
      ext_rise();
      check(tx_data == 1'b1, "R2 idle output", tx_data, 1);
      ext_fall();
      enable_all();
      @(negedge clk);
      check(shift_empty == 1'b1, "R2 nothing leaked", shift_empty, 1);
    end

    // R11: disable in the middle of a frame
    enable_all();
    write_word(8'h00, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin ext_rise(); ext_fall(); end
    write_word(8'h00, 1'b0, 1'b0);  // held word must also be discarded
    tx_en = 1'b0;
    repeat (2) @(negedge clk);
    check(shift_empty == 1'b1 && tx_data == 1'b1, "R11 cleared", {shift_empty, tx_data}, 3);
    tx_en = 1'b1;
    repeat (2) @(negedge clk);
    check(shift_empty == 1'b1, "R11 no held word", shift_empty, 1);
    ext_rise();
    check(tx_data == 1'b1, "R11 idle after re-enable", tx_data, 1);
    ext_fall();

    // R12: third write into full storage is dropped
    irq_en = 1'b1;
    write_word(8'hA5, 1'b0, 1'b0);
    write_word(8'h3C, 1'b1, 1'b1);
    write_word(8'hFF, 1'b0, 1'b0);
    check(buf_empty == 1'b0, "R6 flag low while held", buf_empty, 0);
    shift_word(8'hA5, 1'b0, 1'b0, "R4 first word");
    check(buf_empty == 1'b1 && irq == 1'b1, "R7 flag on transfer", {buf_empty, irq}, 3);
    shift_word(8'h3C, 1'b1, 1'b1, "R12 held word unchanged");
    check(shift_empty == 1'b1, "R12 no third frame", shift_empty, 1);
    ext_rise();
    check(tx_data == 1'b1, "R10 idle after frame", tx_data, 1);
    ext_fall();

    // Random trials: single and paired words, 8/9-bit mix
    for (int t = 0; t < 30; t++) begin
      logic [7:0] d1, d2;
      logic n1, n2, b1, b2, two, had_flag;
      d1 = 8'($urandom); d2 = 8'($urandom);
      n1 = 1'($urandom); n2 = 1'($urandom);
      b1 = 1'($urandom); b2 = 1'($urandom);
      two = 1'($urandom);
      irq_en = 1'($urandom);
      had_flag = buf_empty;
      write_word(d1, n1, b1);
      check(shift_empty == 1'b0, "R3 direct load", shift_empty, 0);
      check(buf_empty == 1'b0, "R8 flag cleared by write", buf_empty, 0);
      if (had_flag) check(irq == 1'b0, "R9 irq drops with flag", irq, 0);
      if (two) begin
        write_word(d2, n2, b2);
        check(buf_empty == 1'b0, "R6 flag stays low", buf_empty, 0);
      end
      shift_word(d1, n1, b1, (n1 ? "R5 nine-bit frame" : "R4 eight-bit frame"));
      if (two) begin
        check(buf_empty == 1'b1, "R7 flag set", buf_empty, 1);
        check(irq == irq_en, "R9 irq gating", irq, irq_en);
        check(shift_empty == 1'b0, "R7 second word loaded", shift_empty, 0);
        shift_word(d2, n2, b2, "R7 second frame");
      end else begin
        check(buf_empty == 1'b0, "R3 no flag on direct load", buf_empty, 0);
      end
      check(shift_empty == 1'b1, "R10 empty after frame", shift_empty, 1);
      ext_rise();
      check(tx_data == 1'b1, "R10 idle level", tx_data, 1);
      ext_fall();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule